// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target Engine

This block is the protocol engine of a byte-addressed EEPROM that answers on a two-wire serial bus. It oversamples the bus clock and data lines with the system clock and recognises start and stop conditions. It shifts words in and out MSB first and acknowledges its own device address. It then runs byte writes, page writes, current-address reads, random reads and sequential reads against a synchronous byte-wide memory port. Data flows only through that memory port. The port has no back-pressure: a write strobe is taken in the cycle it is raised, and read data for `mem_addr` appears one clock later.

Bytes that arrive in a write transfer are held in a page buffer indexed by the low address bits. The buffer is copied to memory only after the closing stop, during a self-timed busy period whose length in system clocks is a parameter. While that period runs the engine ignores the bus completely, so a controller can poll with its device address until an acknowledge returns. A write-protect input suppresses the commit.

Top module: `tw_eeprom_target`

## Requirements
- R1: A falling data line while the clock line is high is a start, and a rising data line while the clock line is high is a stop. Either one, seen outside the busy period, ends the transfer in progress and discards any partly received byte.
- R2: The first byte after a start is `1010`, then A2, A1, a page bit and a read flag (1 = read), MSB first. The engine pulls data low through the ninth clock only if the A2/A1 bits equal `strap_a2`/`strap_a1` and the prefix matches. Otherwise it stays silent and waits for the next start.
- R3: In a write, the two bytes after the device byte form the word address. The 17-bit address is {page bit, first byte, second byte}. Each address and data byte is acknowledged.
- R4: Each data byte advances only the low `PAGE_W` address bits. A page write that runs past the page end wraps to the first byte of the same page.
- R5: Buffered bytes are written to memory only when a stop ends a write that holds at least one complete data byte. A repeated start discards them.
- R6: After a committing stop, the engine ignores the bus for at least `WR_CYCLES` clocks and never acknowledges during that time. It acknowledges again afterwards.
- R7: Memory write strobes occur only during the busy period, one for each distinct buffered byte.
- R8: If `wp` is high at the stop, memory is not written and no busy period starts.
- R9: In a read, data bits change after the clock falls, MSB first. Another byte follows while the controller acknowledges. After a missing acknowledge, `sda_oe` is released.
- R10: A read advances the full 17-bit address, and address 0x1FFFF is followed by 0x00000.
- R11: A current-address read starts at the address after the last byte accessed.
- R12: After reset, `sda_oe` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| strap_a2 | input | 1 | Address strap compared with device byte bit 3 |
| strap_a1 | input | 1 | Address strap compared with device byte bit 2 |
| wp | input | 1 | Write protect, high blocks commits |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 17 | Memory byte address (read and write) |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one clock after `mem_addr` |

## Verification
The two functions that can meet are the commit of a finished write and the address phase of the next transfer. A controller that polls at once sends its start and device byte while the flush and busy timer are still running. The bench provokes this by polling right after each committing stop. It passes only if the poll gets no acknowledge and a later poll gets one. The bench also checks that a stop with `wp` high, or a stop after a repeated start, lets the very next poll be acknowledged, and that read-back data and the count of write strobes match a shadow model.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int ADDR_W = 17;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AH, ST_AL, ST_WD, ST_RD, ST_BUSY
  } tw_state_e;
endpackage

// File: rtl/tw_bus_sampler.sv
module tw_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_s, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= (scl_pipe << 1) | SYNC_STAGES'(scl_i);
      sda_pipe <= (sda_pipe << 1) | SYNC_STAGES'(sda_i);
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s    = scl_pipe[SYNC_STAGES-1];
  assign sda_s    = sda_pipe[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  // R1: data edges while the clock stays high are framing, never data
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tw_addr_ctr.sv
module tw_addr_ctr #(
  parameter int AW     = 17,
  parameter int PAGE_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc_page,
  input  logic          inc_full,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr <= '0;
    else if (load)     ptr <= load_val;
    else if (inc_page) ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
    else if (inc_full) ptr <= ptr + 1'b1;
  end

  a_r4_page_row_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_page && !load) |=> ptr[AW-1:PAGE_W] == $past(ptr[AW-1:PAGE_W]));
  a_r10_top_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_full && !load && !inc_page && ptr == {AW{1'b1}}) |=> ptr == '0);
endmodule

// File: rtl/tw_page_buf.sv
module tw_page_buf #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [7:0]        rd_data,
  output logic              rd_valid
);
  localparam int DEPTH = 1 << PAGE_W;
  logic [7:0]       store [DEPTH];
  logic [DEPTH-1:0] filled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     filled <= '0;
    else if (clr)   filled <= '0;
    else if (wr_en) filled[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_data;
  end

  assign rd_data  = store[rd_idx];
  assign rd_valid = filled[rd_idx];
endmodule

// File: rtl/tw_eeprom_target.sv
module tw_eeprom_target
  import tw_pkg::*;
#(
  parameter int          PAGE_W      = 8,
  parameter int unsigned WR_CYCLES   = 250000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              strap_a2,
  input  logic              strap_a1,
  input  logic              wp,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  localparam int BW = $clog2(WR_CYCLES + 1);
  localparam logic [PAGE_W-1:0] IDX_LAST = '1;

  logic sda_s, scl_rise, scl_fall, start_c, stop_c;
  tw_state_e state, after_ack;
  logic [3:0] cnt;
  logic [7:0] sh, txsh, hi_byte;
  logic p0, mack, got, oe_q, fdone;
  logic [BW-1:0] bcnt;
  logic [PAGE_W-1:0] fidx;
  logic [ADDR_W-1:0] ptr;
  logic [7:0] buf_data;
  logic buf_valid;

  tw_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c));

  // event decode
  logic busy, ev_ok, rx_st, word_done, ack_end, dev_match;
  logic ld, inc_pg, inc_full, dev_to_rd, rd_more, buf_clr;
  assign busy      = (state == ST_BUSY);
  assign ev_ok     = !busy && !start_c && !stop_c;
  assign rx_st     = (state == ST_DEV) || (state == ST_AH) || (state == ST_AL) || (state == ST_WD);
  assign word_done = ev_ok && rx_st && scl_fall && (cnt == 4'd8);
  assign ack_end   = ev_ok && rx_st && scl_fall && (cnt == 4'd9);
  assign dev_match = (sh[7:4] == DEV_PREFIX) && (sh[3] == strap_a2) && (sh[2] == strap_a1);
  assign ld        = word_done && (state == ST_AL);
  assign inc_pg    = word_done && (state == ST_WD);
  assign dev_to_rd = ack_end && (after_ack == ST_RD);
  assign rd_more   = ev_ok && (state == ST_RD) && scl_fall && (cnt == 4'd8) && mack;
  assign inc_full  = dev_to_rd || rd_more;
  assign buf_clr   = start_c && !busy;

  tw_addr_ctr #(.AW(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val({p0, hi_byte, sh}),
    .inc_page(inc_pg), .inc_full(inc_full), .ptr(ptr));

  tw_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(inc_pg),
    .wr_idx(ptr[PAGE_W-1:0]), .wr_data(sh), .rd_idx(fidx),
    .rd_data(buf_data), .rd_valid(buf_valid));

  assign mem_we    = busy && !fdone && buf_valid;
  assign mem_wdata = buf_data;
  assign mem_addr  = busy ? {ptr[ADDR_W-1:PAGE_W], fidx} : ptr;
  assign sda_oe    = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; after_ack <= ST_IDLE; cnt <= '0; sh <= '0; txsh <= '0;
      hi_byte <= '0; p0 <= 1'b0; mack <= 1'b0; got <= 1'b0; oe_q <= 1'b0;
      fdone <= 1'b1; bcnt <= '0; fidx <= '0;
    end else if (busy) begin
      if (bcnt != '0) bcnt <= bcnt - 1'b1;
      if (!fdone) begin
        if (fidx == IDX_LAST) fdone <= 1'b1;
        else                  fidx  <= fidx + 1'b1;
      end
      if (bcnt == '0 && fdone) state <= ST_IDLE;
    end else if (start_c) begin
      state <= ST_DEV; cnt <= '0; oe_q <= 1'b0; got <= 1'b0;
    end else if (stop_c) begin
      cnt  <= '0;
      oe_q <= 1'b0;
      if (state == ST_WD && got && !wp) begin
        state <= ST_BUSY; bcnt <= BW'(WR_CYCLES - 1); fidx <= '0; fdone <= 1'b0;
      end else begin
        state <= ST_IDLE;
      end
    end else if (rx_st) begin
      if (scl_rise && cnt < 4'd8) begin
        sh  <= {sh[6:0], sda_s};
        cnt <= cnt + 1'b1;
      end else if (word_done) begin
        cnt  <= 4'd9;
        oe_q <= 1'b1;
        unique case (state)
          ST_DEV: begin
            p0        <= sh[1];
            after_ack <= sh[0] ? ST_RD : ST_AH;
            if (!dev_match) begin
              state <= ST_IDLE; cnt <= '0; oe_q <= 1'b0;
            end
          end
          ST_AH:   begin hi_byte <= sh; after_ack <= ST_AL; end
          ST_AL:   after_ack <= ST_WD;
          default: begin got <= 1'b1; after_ack <= ST_WD; end
        endcase
      end else if (ack_end) begin
        cnt   <= '0;
        state <= after_ack;
        oe_q  <= 1'b0;
        if (dev_to_rd) begin
          txsh <= mem_rdata;
          oe_q <= ~mem_rdata[7];
        end
      end
    end else if (state == ST_RD) begin
      if (scl_fall && cnt < 4'd7) begin
        txsh <= {txsh[6:0], 1'b0};
        oe_q <= ~txsh[6];
        cnt  <= cnt + 1'b1;
      end else if (scl_fall && cnt == 4'd7) begin
        oe_q <= 1'b0;
        cnt  <= 4'd8;
      end else if (scl_rise && cnt == 4'd8) begin
        mack <= ~sda_s;
      end else if (scl_fall && cnt == 4'd8) begin
        cnt <= '0;
        if (mack) begin
          txsh <= mem_rdata;
          oe_q <= ~mem_rdata[7];
        end else begin
          state <= ST_IDLE;
        end
      end
    end
  end

  a_r7_we_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> state == ST_BUSY);
  a_r6_silent_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY) |-> !sda_oe);
  a_r8_wp_blocks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_c && wp && state != ST_BUSY) |=> state != ST_BUSY);
  a_r9_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD && scl_fall && cnt == 4'd8 && !mack && !start_c && !stop_c)
      |=> (!sda_oe && state == ST_IDLE));
endmodule

// File: tb/tw_eeprom_target_test.sv
module tw_eeprom_target_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int WRC = 600;
  localparam logic STRAP2 = 1'b1;
  localparam logic STRAP1 = 1'b0;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, mem_we;
  logic [16:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  wire sda_line = sda_m & ~sda_oe;
  int checks = 0, errors = 0, we_cnt = 0;
  logic [7:0] model [int];
  logic [7:0] rbuf [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_eeprom_target #(.PAGE_W(8), .WR_CYCLES(WRC), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_a2(STRAP2), .strap_a1(STRAP1), .wp(wp), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (mem_we) begin
      model[int'(mem_addr)] = mem_wdata;
      we_cnt = we_cnt + 1;
    end
  end
  always @(posedge clk)
    mem_rdata <= model.exists(int'(mem_addr)) ? model[int'(mem_addr)] : 8'hFF;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  function automatic logic [7:0] dev(input logic pg, input logic rd);
    return {4'b1010, STRAP2, STRAP1, pg, rd};
  endfunction

  task automatic m_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask
  task automatic m_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask
  task automatic m_wbit(input logic b);
    sda_m = b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask
  task automatic m_rbit(output logic b);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); b = sda_line; q(); scl_m = 1'b0; q();
  endtask
  task automatic m_wbyte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) m_wbit(d[i]);
    m_rbit(ack);
  endtask
  task automatic m_rbyte(output logic [7:0] d, input logic last);
    logic b;
    for (int i = 7; i >= 0; i--) begin m_rbit(b); d[i] = b; end
    m_wbit(last);
  endtask

  task automatic wr_bytes(input logic [16:0] a, input int n, input logic [7:0] b0,
                          input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3);
    logic ack;
    logic [7:0] d;
    m_start();
    m_wbyte(dev(a[16], 1'b0), ack); chk("R2 device ack", ack, 0);
    m_wbyte(a[15:8], ack); chk("R3 high addr ack", ack, 0);
    m_wbyte(a[7:0], ack);  chk("R3 low addr ack", ack, 0);
    for (int i = 0; i < n; i++) begin
      d = (i == 0) ? b0 : (i == 1) ? b1 : (i == 2) ? b2 : b3;
      m_wbyte(d, ack); chk("R3 data ack", ack, 0);
    end
    m_stop();
  endtask

  task automatic rd_tail(input int n);
    for (int i = 0; i < n; i++) m_rbyte(rbuf[i], i == n - 1);
    q();
    chk("R9 released after nack", sda_oe, 0);
    m_stop();
  endtask
  task automatic rd_random(input logic [16:0] a, input int n);
    logic ack;
    m_start();
    m_wbyte(dev(a[16], 1'b0), ack); m_wbyte(a[15:8], ack); m_wbyte(a[7:0], ack);
    m_start();
    m_wbyte(dev(a[16], 1'b1), ack); chk("R2 read device ack", ack, 0);
    rd_tail(n);
  endtask
  task automatic rd_current(input int n);
    logic ack;
    m_start();
    m_wbyte(dev(1'b0, 1'b1), ack); chk("R11 current read ack", ack, 0);
    rd_tail(n);
  endtask
  task automatic poll(output logic ack);
    m_start(); m_wbyte(dev(1'b0, 1'b0), ack); m_stop();
  endtask
  task automatic wait_ready();
    repeat (WRC + 300) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R12 sda_oe after reset", sda_oe, 0);
    chk("R12 mem_we after reset", mem_we, 0);
  endtask

  task automatic t_mismatch();
    logic ack;
    m_start(); m_wbyte({4'b1010, ~STRAP2, STRAP1, 2'b00}, ack); m_stop();
    chk("R2 strap mismatch no ack", ack, 1);
    m_start(); m_wbyte({4'b1011, STRAP2, STRAP1, 2'b00}, ack); m_stop();
    chk("R2 prefix mismatch no ack", ack, 1);
    poll(ack);
    chk("R2 match acks", ack, 0);
  endtask

  task automatic t_byte_write();
    logic ack;
    wr_bytes(17'h12345, 1, 8'hA7, 0, 0, 0);
    poll(ack); chk("R6 no ack while busy", ack, 1);
    wait_ready();
    poll(ack); chk("R6 ack after busy", ack, 0);
    rd_random(17'h12345, 1);
    chk("R3 readback with page bit", rbuf[0], 8'hA7);
  endtask

  task automatic t_page_wrap();
    int w0;
    w0 = we_cnt;
    wr_bytes(17'h005FE, 4, 8'h11, 8'h22, 8'h33, 8'h44);
    wait_ready();
    chk("R7 one strobe per byte", we_cnt - w0, 4);
    rd_random(17'h00500, 2);
    chk("R4 wrap byte 0", rbuf[0], 8'h33);
    chk("R4 wrap byte 1", rbuf[1], 8'h44);
    rd_random(17'h005FE, 2);
    chk("R4 page end byte", rbuf[0], 8'h11);
    chk("R4 page last byte", rbuf[1], 8'h22);
  endtask

  task automatic t_read_wrap();
    wr_bytes(17'h00000, 2, 8'h5A, 8'h5B, 0, 0); wait_ready();
    wr_bytes(17'h1FFFF, 1, 8'hC3, 0, 0, 0);    wait_ready();
    rd_random(17'h1FFFF, 2);
    chk("R10 top byte", rbuf[0], 8'hC3);
    chk("R10 wrap to zero", rbuf[1], 8'h5A);
    rd_current(1);
    chk("R11 next after last read", rbuf[0], 8'h5B);
  endtask

  task automatic t_wp();
    logic ack;
    int w0;
    w0 = we_cnt;
    wp = 1'b1;
    wr_bytes(17'h00010, 1, 8'h77, 0, 0, 0);
    poll(ack); chk("R8 no busy when protected", ack, 0);
    wp = 1'b0;
    wait_ready();
    chk("R8 no strobes when protected", we_cnt - w0, 0);
    rd_random(17'h00010, 1);
    chk("R8 data unchanged", rbuf[0], 8'hFF);
  endtask

  task automatic t_abort();
    logic ack;
    m_start();
    m_wbyte(dev(1'b0, 1'b0), ack); m_wbyte(8'h00, ack); m_wbyte(8'h20, ack);
    m_wbyte(8'h11, ack);
    m_start();  // R1 repeated start aborts
    m_wbyte(dev(1'b0, 1'b0), ack); m_wbyte(8'h00, ack); m_wbyte(8'h40, ack);
    m_stop();
    poll(ack); chk("R5 restart leaves nothing to commit", ack, 0);
    rd_random(17'h00020, 1);
    chk("R5 aborted byte not written", rbuf[0], 8'hFF);
    m_start();
    m_wbyte(dev(1'b0, 1'b0), ack); m_wbyte(8'h00, ack); m_wbyte(8'h30, ack);
    m_wbyte(8'h22, ack);
    m_wbit(1'b1); m_wbit(1'b0); m_wbit(1'b1); m_wbit(1'b0);
    m_stop();  // R1 stop mid byte
    poll(ack); chk("R5 full byte commits", ack, 1);
    wait_ready();
    rd_random(17'h00030, 2);
    chk("R5 complete byte written", rbuf[0], 8'h22);
    chk("R1 partial byte dropped", rbuf[1], 8'hFF);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_mismatch();
    t_byte_write();
    t_page_wrap();
    t_read_wrap();
    t_wp();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule